// File: doc/BRIEF.md
# Evolution Stall Trigger

This block sits beside an evolutionary search engine that reports the best fitness of its population once per generation. It decides when the search should stop and hand the nearly working circuit to a repair stage. Two conditions can end the search, and they have a fixed priority. The first is a fitness value at or above an absolute threshold. The second is a run of generations in which the best fitness has not changed.

The threshold is derived at elaboration time. It is the ceiling of 95% of the largest fitness the search can reach. On every generation strobe the threshold is tested first. The stall counter is updated and compared against its limit only when the threshold is missed. When either condition fires, the block emits a single-cycle start pulse for the repair stage and latches a reason code. It then stays in a finished state until the engine asserts start again. Start both clears the block and arms it.

Top module: `evo_stall_trigger`

## Requirements
- R1: After reset, repair_go, done, reason and stall_cnt are all zero. Generation strobes have no effect until start has been asserted once.
- R2: A cycle with start high clears stall_cnt, done and reason and arms the block. The effect is visible after the next clock edge.
- R3: For an armed block, a strobe with best_fit at or above TH = ceil(0.95 * FIT_MAX) gives repair_go high for one cycle and reason 2'b01 after the next edge. stall_cnt keeps its value.
- R4: For an armed block, a strobe with best_fit below TH and equal to the previous strobe's value increments stall_cnt by one.
- R5: For an armed block, a strobe with best_fit below TH and different from the previous value sets stall_cnt to zero.
- R6: The first strobe after start has no previous value to compare against. It counts as a change, so stall_cnt stays zero.
- R7: When the updated stall_cnt reaches STALL_LIMIT, repair_go pulses and reason becomes 2'b10.
- R8: repair_go is high for exactly one clock per trigger and only while done is high. done stays high until start.
- R9: While done is high, strobes without start leave stall_cnt and reason unchanged and produce no pulse.
- R10: The threshold test takes priority. A strobe at or above TH that also repeats the previous value gives reason 2'b01 and leaves stall_cnt unchanged.
- R11: stall_cnt never exceeds STALL_LIMIT and never wraps.
- R12: When start and a strobe arrive in the same cycle, start wins and the strobe is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Clear and arm for a new search |
| gen_vld | input | 1 | One-cycle strobe per generation |
| best_fit | input | FIT_W | Best fitness of the generation |
| repair_go | output | 1 | One-cycle repair start pulse |
| reason | output | 2 | 01 threshold reached, 10 stall limit reached |
| done | output | 1 | Search finished, reason valid |
| stall_cnt | output | $clog2(STALL_LIMIT+1) | Generations without improvement |

## Verification
The bench places fitness values on both sides of the rounded threshold: 192 misses and 193 fires for a maximum of 203. A design that truncated instead of rounding up, or that used a strict compare, would miss or fire at the wrong value. A value that repeats the previous one while crossing the threshold tests the priority. A design that updated the counter first would report a stall or move the count. The bench also checks that the first strobe after start counts as a change, that start wins over a coincident strobe, and that strobes after the trigger do nothing. Without these, the count would begin at one, a stale comparison would survive the clear, or a second pulse would appear.

// File: rtl/evo_stall_trigger.sv
module evo_stall_trigger #(
  parameter int FIT_W       = 16,
  parameter int FIT_MAX     = 1000,
  parameter int STALL_LIMIT = 300,
  localparam int CNT_W      = $clog2(STALL_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             gen_vld,
  input  logic [FIT_W-1:0] best_fit,
  output logic             repair_go,
  output logic [1:0]       reason,
  output logic             done,
  output logic [CNT_W-1:0] stall_cnt
);

  localparam int TH = (FIT_MAX * 95 + 99) / 100;
  localparam logic [FIT_W-1:0] TH_V  = TH[FIT_W-1:0];
  localparam logic [CNT_W-1:0] LIM_V = STALL_LIMIT[CNT_W-1:0];
  localparam logic [CNT_W-1:0] SAT_V = {CNT_W{1'b1}};

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} st_t;

  st_t              st;
  logic [FIT_W-1:0] prev_fit;
  logic             have_prev;
  logic [CNT_W-1:0] sg;
  logic [1:0]       why;
  logic             go;

  logic             running;
  logic             eval;
  logic             hit_th;
  logic             same;
  logic [CNT_W-1:0] sg_nxt;
  logic             stalled;

  assign running = (st == ST_RUN);
  assign eval    = running && gen_vld && !start;
  assign hit_th  = best_fit >= TH_V;
  assign same    = have_prev && (best_fit == prev_fit);
  assign sg_nxt  = !same ? '0 : (sg == SAT_V) ? sg : sg + 1'b1;
  assign stalled = sg_nxt >= LIM_V;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      prev_fit  <= '0;
      have_prev <= 1'b0;
      sg        <= '0;
      why       <= 2'b00;
      go        <= 1'b0;
    end else begin
      go <= 1'b0;
      if (start) begin
        st        <= ST_RUN;
        sg        <= '0;
        have_prev <= 1'b0;
        why       <= 2'b00;
      end else if (eval) begin
        if (hit_th) begin
          go  <= 1'b1;
          why <= 2'b01;
          st  <= ST_DONE;
        end else begin
          sg        <= sg_nxt;
          prev_fit  <= best_fit;
          have_prev <= 1'b1;
          if (stalled) begin
            go  <= 1'b1;
            why <= 2'b10;
            st  <= ST_DONE;
          end
        end
      end
    end
  end

  assign repair_go = go;
  assign reason    = why;
  assign done      = (st == ST_DONE);
  assign stall_cnt = sg;

endmodule

// File: rtl/evo_stall_trigger_chk.sv
module evo_stall_trigger_chk #(
  parameter int FIT_W = 16,
  parameter int TH    = 950,
  parameter int LIMIT = 300,
  parameter int CW    = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             gen_vld,
  input logic [FIT_W-1:0] best_fit,
  input logic             running,
  input logic             repair_go,
  input logic [1:0]       reason,
  input logic             done,
  input logic [CW-1:0]    stall_cnt
);

  // R8
  go_one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    repair_go |=> !repair_go);

  // R8
  go_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    repair_go |-> done);

  // R3
  threshold_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && gen_vld && !start && (int'(best_fit) >= TH))
      |=> (repair_go && reason == 2'b01 && $stable(stall_cnt)));

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && !repair_go && $stable(stall_cnt) && $stable(reason)));

  // R11
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(stall_cnt) <= LIMIT);

  // R2
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (stall_cnt == '0 && !done && !repair_go && reason == 2'b00));

endmodule

bind evo_stall_trigger evo_stall_trigger_chk #(
  .FIT_W(FIT_W), .TH(TH), .LIMIT(STALL_LIMIT), .CW(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .gen_vld(gen_vld),
  .best_fit(best_fit), .running(running), .repair_go(repair_go),
  .reason(reason), .done(done), .stall_cnt(stall_cnt)
);

// File: tb/test_evo_stall_trigger.sv
module test_evo_stall_trigger;
  localparam int FW  = 8;
  localparam int LIM = 4;
  localparam int CW  = 3;
  localparam int TH  = 193;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          gen_vld = 1'b0;
  logic [FW-1:0] best_fit = '0;
  logic          repair_go;
  logic [1:0]    reason;
  logic          done;
  logic [CW-1:0] stall_cnt;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  evo_stall_trigger #(.FIT_W(FW), .FIT_MAX(203), .STALL_LIMIT(LIM)) i_evo_stall_trigger (
    .clk(clk), .rst_n(rst_n), .start(start), .gen_vld(gen_vld), .best_fit(best_fit),
    .repair_go(repair_go), .reason(reason), .done(done), .stall_cnt(stall_cnt)
  );

  typedef struct {
    logic       go;
    logic [1:0] rsn;
    logic       dn;
    int         cnt;
    string      tag;
  } exp_t;

  exp_t q[$];

  bit   m_run = 0, m_done = 0, m_have = 0;
  int   m_sg = 0, m_prev = 0;
  logic [1:0] m_rsn = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit v, input bit s, input int f, input string tag);
    exp_t e;
    @(negedge clk);
    gen_vld = v; start = s; best_fit = f[FW-1:0];
    e.go = 1'b0;
    if (s) begin
      m_run = 1; m_done = 0; m_sg = 0; m_have = 0; m_rsn = 2'b00;
    end else if (v && m_run && !m_done) begin
      if (f >= TH) begin
        e.go = 1'b1; m_rsn = 2'b01; m_done = 1;
      end else begin
        if (m_have && f == m_prev) m_sg = (m_sg < 7) ? m_sg + 1 : m_sg;
        else m_sg = 0;
        m_prev = f; m_have = 1;
        if (m_sg >= LIM) begin
          e.go = 1'b1; m_rsn = 2'b10; m_done = 1;
        end
      end
    end
    e.rsn = m_rsn; e.dn = m_done; e.cnt = m_sg; e.tag = tag;
    @(posedge clk);
    #1;
    q.push_back(e);
    gen_vld = 1'b0; start = 1'b0;
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.tag, "repair_go", int'(repair_go), int'(e.go));
      chk(e.tag, "reason", int'(reason), int'(e.rsn));
      chk(e.tag, "done", int'(done), int'(e.dn));
      chk(e.tag, "stall_cnt", int'(stall_cnt), e.cnt);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset repair_go", int'(repair_go), 0);
    chk("R1", "reset done", int'(done), 0);
    chk("R1", "reset stall_cnt", int'(stall_cnt), 0);
    rst_n = 1'b1;
    step(1, 0, 50, "R1");
    step(1, 0, 50, "R1");
    step(0, 1, 0, "R2");
    step(1, 0, 50, "R6");
    step(1, 0, 50, "R4");
    step(1, 0, 50, "R4");
    step(1, 0, 60, "R5");
    step(1, 0, 60, "R4");
    step(1, 0, 60, "R4");
    step(1, 0, 60, "R4");
    step(1, 0, 60, "R7");
    step(0, 0, 0, "R8");
    step(1, 0, 60, "R9");
    step(1, 0, 250, "R9");
    step(0, 1, 0, "R2");
    step(1, 0, 192, "R3");
    step(1, 0, 193, "R3");
    step(0, 0, 0, "R8");
    step(0, 1, 0, "R2");
    step(1, 0, 100, "R6");
    step(1, 0, 100, "R4");
    step(1, 0, 100, "R4");
    step(1, 0, 250, "R10");
    step(0, 1, 0, "R2");
    step(1, 0, 10, "R6");
    step(1, 0, 10, "R4");
    step(1, 1, 10, "R12");
    step(1, 0, 10, "R12");
    step(1, 0, 10, "R11");
    step(1, 0, 10, "R11");
    step(1, 0, 10, "R11");
    step(1, 0, 10, "R11");
    step(1, 0, 10, "R11");
    step(0, 0, 0, "R8");
    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule